// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel flash device. After software has started an embedded program or erase operation, it pulses `start_i`. The block then reads the device status word repeatedly through a simple request/acknowledge bus port and watches two status bits. The toggle bit flips on every read while the operation is still running. The timeout bit goes high when the device's internal algorithm has run past its limit. From these two bits the block decides whether the operation finished cleanly, failed, or is still running.

The toggle decision is never made on one compare. When the toggle bit still differs and the timeout bit is high, the block takes two more reads and tests toggling again, because toggling may have stopped on the same read that the timeout bit rose. A real failure causes the block to write the reset command so the device returns to array reads. It then reports a one-cycle result pulse. An optional programmable poll limit guards against a device whose timeout bit never rises. `abort_i` drops the block back to idle at any time, and the next start always begins with a fresh pair of reads.

Top module: `toggle_poller`

## Requirements
- R1: While reset is held and in the first cycle after it, `bus_req_o`, `busy_o`, `done_o`, `pass_o` and `fail_o` are all low.
- R2: A `start_i` pulse seen while idle causes two status reads from the address on `stat_addr_i`. If bit 6 of the two reads is equal, the block reports pass and writes nothing. This holds even when bit 5 is high.
- R3: If bit 6 differs between two consecutive reads and bit 5 of the later read is high, exactly two further reads follow, and bit 6 is compared across them.
- R4: If that re-check shows equal bit 6 values, the result is pass. If they differ, the block writes the data value 0xF0 once to the status address and then reports fail.
- R5: If bit 6 differs and bit 5 of the later read is low, one more read is taken and compared with the read before it. This repeats until a result is reached.
- R6: When `abort_i` is high at a clock edge, the block goes idle in the next cycle, drops its request, and produces no result pulse. A later start begins again with two fresh reads, and no value from before the abort is reused.
- R7: When `max_polls_i` is N (not zero) and N consecutive compares show bit 6 differing with bit 5 low, the block writes 0xF0 and reports fail. When `max_polls_i` is 0, polling has no limit.
- R8: `done_o` is high for exactly one cycle per run, the cycle after the clock edge at which the final access was acknowledged. Exactly one of `pass_o`/`fail_o` is high alongside it. A start pulse while busy is ignored.
- R9: Once raised, `bus_req_o` stays high with stable address, write enable and write data until `bus_ack_i` is sampled high, unless an abort intervenes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin polling (ignored while busy) |
| abort_i | input | 1 | Leave polling and return to idle |
| stat_addr_i | input | AW | Address used for status reads and the reset write; captured at start |
| max_polls_i | input | CW | Limit on toggling compares with bit 5 low; 0 disables the limit |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | High for a write, low for a read |
| bus_addr_o | output | AW | Access address |
| bus_wdata_o | output | DW | Write data (0xF0 during the reset write) |
| bus_ack_i | input | 1 | Access acknowledge; read data valid with it |
| bus_rdata_i | input | DW | Read data |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | One-cycle result strobe |
| pass_o | output | 1 | Operation completed successfully (with done) |
| fail_o | output | 1 | Operation failed (with done) |

## Verification
A read result is consumed on the clock edge where acknowledge is high. The next request, or the result pulse, appears in the cycle after that edge. The bench's bus model raises acknowledge on one falling edge and clears it on the next, so every access takes two cycles. All outputs are sampled one nanosecond after a falling edge, well away from the rising edge. The result check waits for the first cycle in which `done_o` is high. It compares `pass_o`/`fail_o` in that same sample, confirms in the following sample that the strobe has fallen, and then compares the read and write counts gathered by the bus model with the counts the scripted status sequence should produce.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FIRST = 3'd1,
      ST_NEXT  = 3'd2,
      ST_RE_A  = 3'd3,
      ST_RE_B  = 3'd4,
      ST_RESET = 3'd5
   } poll_state_e;

   typedef enum logic [1:0] {
      BUS_NONE  = 2'd0,
      BUS_READ  = 2'd1,
      BUS_WRITE = 2'd2
   } bus_op_e;

endpackage

// File: rtl/tbp_bus_port.sv
module tbp_bus_port
   import tbp_pkg::*;
#(
   parameter int              AW      = 20,
   parameter int              DW      = 8,
   parameter int              TOG_BIT = 6,
   parameter int              TMO_BIT = 5,
   parameter logic [DW-1:0]   RST_CMD = 8'hF0
) (
   input  bus_op_e         op,
   input  logic [AW-1:0]   addr_in,
   input  logic [DW-1:0]   rdata,
   output logic            req,
   output logic            we,
   output logic [AW-1:0]   addr,
   output logic [DW-1:0]   wdata,
   output logic            tog,
   output logic            tmo
);

   logic unused_rd;

   assign req       = (op != BUS_NONE);
   assign we        = (op == BUS_WRITE);
   assign addr      = addr_in;
   assign wdata     = (op == BUS_WRITE) ? RST_CMD : '0;
   assign tog       = rdata[TOG_BIT];
   assign tmo       = rdata[TMO_BIT];
   assign unused_rd = ^rdata;

endmodule

// File: rtl/tbp_toggle_cmp.sv
module tbp_toggle_cmp (
   input  logic clk,
   input  logic rst_n,
   input  logic capture,
   input  logic cur,
   output logic differs
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prev_q <= 1'b0;
      else if (capture) prev_q <= cur;
   end

   assign differs = cur ^ prev_q;

endmodule

// File: rtl/tbp_poll_limit.sv
module tbp_poll_limit #(
   parameter int CW        = 16,
   parameter bit USE_LIMIT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   input  logic [CW-1:0] max_i,
   output logic          last
);

   generate
      if (USE_LIMIT) begin : g_limit
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt_q <= '0;
            else if (clear) cnt_q <= '0;
            else if (step)  cnt_q <= cnt_q + CW'(1);
         end

         assign last = (max_i != '0) && (cnt_q == max_i - CW'(1));
      end else begin : g_nolimit
         logic unused_lim;
         assign unused_lim = ^{clk, rst_n, clear, step, max_i};
         assign last       = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/tbp_fsm.sv
module tbp_fsm
   import tbp_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  logic    abort,
   input  logic    ack,
   input  logic    differs,
   input  logic    tmo,
   input  logic    last,
   output bus_op_e op,
   output logic    capture,
   output logic    step,
   output logic    clear,
   output logic    busy,
   output logic    done,
   output logic    pass,
   output logic    fail
);

   poll_state_e state_q, nxt;
   logic        fin_pass, fin_fail;
   logic        done_q, pass_q, fail_q;

   always_comb begin
      nxt      = state_q;
      capture  = 1'b0;
      step     = 1'b0;
      fin_pass = 1'b0;
      fin_fail = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) nxt = ST_FIRST;
         end
         ST_FIRST: begin
            if (ack) begin
               capture = 1'b1;
               nxt     = ST_NEXT;
            end
         end
         ST_NEXT: begin
            if (ack) begin
               capture = 1'b1;
               if (!differs) begin
                  fin_pass = 1'b1;
                  nxt      = ST_IDLE;
               end else if (tmo) begin
                  nxt = ST_RE_A;
               end else if (last) begin
                  nxt = ST_RESET;
               end else begin
                  step = 1'b1;
               end
            end
         end
         ST_RE_A: begin
            if (ack) begin
               capture = 1'b1;
               nxt     = ST_RE_B;
            end
         end
         ST_RE_B: begin
            if (ack) begin
               if (!differs) begin
                  fin_pass = 1'b1;
                  nxt      = ST_IDLE;
               end else begin
                  nxt = ST_RESET;
               end
            end
         end
         ST_RESET: begin
            if (ack) begin
               fin_fail = 1'b1;
               nxt      = ST_IDLE;
            end
         end
         default: nxt = ST_IDLE;
      endcase
      if (abort) begin
         nxt      = ST_IDLE;
         step     = 1'b0;
         fin_pass = 1'b0;
         fin_fail = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
         pass_q  <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         state_q <= nxt;
         done_q  <= fin_pass | fin_fail;
         pass_q  <= fin_pass;
         fail_q  <= fin_fail;
      end
   end

   always_comb begin
      unique case (state_q)
         ST_FIRST, ST_NEXT, ST_RE_A, ST_RE_B: op = BUS_READ;
         ST_RESET:                            op = BUS_WRITE;
         default:                             op = BUS_NONE;
      endcase
   end

   assign clear = (state_q == ST_IDLE);
   assign busy  = (state_q != ST_IDLE);
   assign done  = done_q;
   assign pass  = pass_q;
   assign fail  = fail_q;

endmodule

// File: rtl/toggle_poller.sv
module toggle_poller
   import tbp_pkg::*;
#(
   parameter int            AW        = 20,
   parameter int            DW        = 8,
   parameter int            CW        = 16,
   parameter int            TOG_BIT   = 6,
   parameter int            TMO_BIT   = 5,
   parameter bit            USE_LIMIT = 1'b1,
   parameter logic [DW-1:0] RST_CMD   = 8'hF0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          abort_i,
   input  logic [AW-1:0] stat_addr_i,
   input  logic [CW-1:0] max_polls_i,
   output logic          bus_req_o,
   output logic          bus_we_o,
   output logic [AW-1:0] bus_addr_o,
   output logic [DW-1:0] bus_wdata_o,
   input  logic          bus_ack_i,
   input  logic [DW-1:0] bus_rdata_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          pass_o,
   output logic          fail_o
);

   initial begin
      assert (TOG_BIT >= 0 && TOG_BIT < DW && TMO_BIT >= 0 && TMO_BIT < DW)
         else $error("status bit position outside data width");
      assert (TOG_BIT != TMO_BIT)
         else $error("toggle and timeout bits must differ");
      assert (AW > 0 && CW > 0)
         else $error("address and counter widths must be positive");
   end

   bus_op_e       op;
   logic          capture, step, clear, busy, last;
   logic          tog, tmo, differs;
   logic [AW-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                addr_q <= '0;
      else if (start_i && !busy) addr_q <= stat_addr_i;
   end

   tbp_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_i),
      .abort   (abort_i),
      .ack     (bus_ack_i),
      .differs (differs),
      .tmo     (tmo),
      .last    (last),
      .op      (op),
      .capture (capture),
      .step    (step),
      .clear   (clear),
      .busy    (busy),
      .done    (done_o),
      .pass    (pass_o),
      .fail    (fail_o)
   );

   tbp_bus_port #(
      .AW(AW), .DW(DW), .TOG_BIT(TOG_BIT), .TMO_BIT(TMO_BIT), .RST_CMD(RST_CMD)
   ) u_port (
      .op      (op),
      .addr_in (addr_q),
      .rdata   (bus_rdata_i),
      .req     (bus_req_o),
      .we      (bus_we_o),
      .addr    (bus_addr_o),
      .wdata   (bus_wdata_o),
      .tog     (tog),
      .tmo     (tmo)
   );

   tbp_toggle_cmp u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .cur     (tog),
      .differs (differs)
   );

   tbp_poll_limit #(.CW(CW), .USE_LIMIT(USE_LIMIT)) u_lim (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clear),
      .step  (step),
      .max_i (max_polls_i),
      .last  (last)
   );

   assign busy_o = busy;

endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
   parameter int            AW      = 20,
   parameter int            DW      = 8,
   parameter logic [DW-1:0] RST_CMD = 8'hF0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          abort_i,
   input logic          bus_req_o,
   input logic          bus_we_o,
   input logic [AW-1:0] bus_addr_o,
   input logic [DW-1:0] bus_wdata_o,
   input logic          bus_ack_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          pass_o,
   input logic          fail_o
);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_ack_i && !abort_i) |=> bus_req_o); // R9

   AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_ack_i && !abort_i) |=>
         ($stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o))); // R9

   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $onehot({pass_o, fail_o})); // R8

   AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> (!pass_o && !fail_o)); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R8

   AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(bus_req_o && bus_ack_i)); // R8

   AST_RESET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_we_o) |-> (bus_wdata_o == RST_CMD)); // R4

   AST_FAIL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> $past(bus_req_o && bus_we_o && bus_ack_i)); // R4

   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      abort_i |=> (!bus_req_o && !done_o && !busy_o)); // R6

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && !abort_i) |=> busy_o); // R2

endmodule

bind toggle_poller tbp_checker #(.AW(AW), .DW(DW), .RST_CMD(RST_CMD)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .abort_i     (abort_i),
   .bus_req_o   (bus_req_o),
   .bus_we_o    (bus_we_o),
   .bus_addr_o  (bus_addr_o),
   .bus_wdata_o (bus_wdata_o),
   .bus_ack_i   (bus_ack_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .pass_o      (pass_o),
   .fail_o      (fail_o)
);

// File: tb/sim_toggle_poller.sv
`timescale 1ns/1ps
module sim_toggle_poller;

   localparam int AW = 20;
   localparam int DW = 8;
   localparam int CW = 16;
   localparam logic [AW-1:0] STAT_A = 20'h5A5A5;

   // {toggle bits by read, timeout bits by read, limit, fail, reads, writes}
   localparam logic [29:0] VECS [0:7] = '{
      {8'b00000000, 8'b00000000, 8'd4, 1'b0, 4'd2, 1'b0},  // R2 equal pair
      {8'b00001110, 8'b00000010, 8'd4, 1'b0, 4'd4, 1'b0},  // R3 R4 recheck passes
      {8'b00001010, 8'b00000010, 8'd4, 1'b1, 4'd4, 1'b1},  // R4 recheck toggles
      {8'b00000010, 8'b00000000, 8'd8, 1'b0, 4'd4, 1'b0},  // R5 keep polling
      {8'b00000010, 8'b00000000, 8'd2, 1'b1, 4'd3, 1'b1},  // R7 limit reached
      {8'b00000101, 8'b00000100, 8'd8, 1'b0, 4'd5, 1'b0},  // R5 then R3
      {8'b00000011, 8'b00000011, 8'd4, 1'b0, 4'd2, 1'b0},  // R2 timeout bit ignored
      {8'b01101010, 8'b00000000, 8'd0, 1'b0, 4'd7, 1'b0}   // R7 unlimited
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          abort_i = 1'b0;
   logic [AW-1:0] stat_addr_i = STAT_A;
   logic [CW-1:0] max_polls_i = '0;
   logic          bus_req_o, bus_we_o;
   logic [AW-1:0] bus_addr_o;
   logic [DW-1:0] bus_wdata_o;
   logic          bus_ack_i = 1'b0;
   logic [DW-1:0] bus_rdata_i = '0;
   logic          busy_o, done_o, pass_o, fail_o;

   int checks = 0;
   int misses = 0;
   int rd_cnt = 0, wr_cnt = 0, done_cnt = 0, addr_err = 0, cyc = 0;
   int rd_base = 0;
   logic [DW-1:0] last_wdata = '0;
   logic          lat_we = 1'b0;
   logic [AW-1:0] lat_addr = '0;
   logic [DW-1:0] lat_wdata = '0;
   logic scr_tog [0:15];
   logic scr_tmo [0:15];

   always #2 clk = ~clk;

   toggle_poller u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
      .stat_addr_i(stat_addr_i), .max_polls_i(max_polls_i),
      .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
      .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
      .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
   );

   // bus model: ack on one falling edge, consumed at the next rising edge
   always @(negedge clk) begin
      if (bus_ack_i) begin
         bus_ack_i = 1'b0;
         if (lat_addr != STAT_A) addr_err++;
         if (lat_we) begin
            wr_cnt++;
            last_wdata = lat_wdata;
         end else begin
            rd_cnt++;
         end
      end else if (bus_req_o) begin
         int idx;
         idx = (rd_cnt - rd_base) & 15;
         lat_we    = bus_we_o;
         lat_addr  = bus_addr_o;
         lat_wdata = bus_wdata_o;
         bus_rdata_i = {1'b1, scr_tog[idx], scr_tmo[idx], 4'b0000, idx[0]};
         bus_ack_i = 1'b1;
      end
      if (done_o) done_cnt++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         misses++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected below 150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         misses++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic load_script(input logic [7:0] tg, input logic [7:0] tm);
      for (int k = 0; k < 16; k++) begin
         scr_tog[k] = (k < 8) ? tg[k] : tg[7];
         scr_tmo[k] = (k < 8) ? tm[k] : 1'b0;
      end
   endtask

   task automatic pulse_start();
      start_i = 1'b1;
      tick();
      start_i = 1'b0;
   endtask

   // waits for the result strobe; returns 0 if it never came
   task automatic wait_done(output bit seen, output bit p, output bit f);
      seen = 1'b0; p = 1'b0; f = 1'b0;
      for (int k = 0; k < 400 && !seen; k++) begin
         if (done_o) begin
            seen = 1'b1;
            p = pass_o;
            f = fail_o;
         end else begin
            tick();
         end
      end
   endtask

   initial begin
      bit seen, p, f;
      int wb, db;
      load_script(8'h00, 8'h00);

      // reset state
      tick();
      check(!bus_req_o && !busy_o && !done_o && !pass_o && !fail_o, "R1 in reset",
            {bus_req_o, busy_o, done_o, pass_o, fail_o}, 0);
      tick();
      rst_n = 1'b1;
      tick();
      check(!bus_req_o && !busy_o && !done_o, "R1 after reset",
            {bus_req_o, busy_o, done_o}, 0);

      // vector table
      for (int i = 0; i < 8; i++) begin
         logic [29:0] v;
         v = VECS[i];
         load_script(v[29:22], v[21:14]);
         max_polls_i = {8'h00, v[13:6]};
         rd_base = rd_cnt;
         wb = wr_cnt;
         pulse_start();
         wait_done(seen, p, f);
         check(seen, "R8 result strobe seen", seen, 1);
         check(f == v[5] && p == !v[5], "R2 R4 R7 pass/fail outcome", {p, f}, {!v[5], v[5]});
         check(rd_cnt - rd_base == int'(v[4:1]), "R3 R5 read count", rd_cnt - rd_base, v[4:1]);
         check(wr_cnt - wb == int'(v[0]), "R4 R7 reset write count", wr_cnt - wb, v[0]);
         if (v[0]) check(last_wdata == 8'hF0, "R4 reset command data", last_wdata, 8'hF0);
         tick();
         check(!done_o && !busy_o, "R8 strobe one cycle", {done_o, busy_o}, 0);
      end
      check(addr_err == 0, "R2 status address used", addr_err, 0);

      // abort after one read, restart: fresh pair 1,1 must pass in two reads
      load_script(8'h00, 8'h00);
      max_polls_i = 16'd8;
      rd_base = rd_cnt;
      db = done_cnt;
      pulse_start();
      for (int k = 0; k < 40 && rd_cnt - rd_base < 1; k++) tick();
      abort_i = 1'b1;
      tick();
      abort_i = 1'b0;
      check(!busy_o && !bus_req_o, "R6 idle after abort", {busy_o, bus_req_o}, 0);
      for (int k = 0; k < 6; k++) tick();
      check(done_cnt == db, "R6 no strobe after abort", done_cnt - db, 0);
      load_script(8'hFF, 8'h00);
      rd_base = rd_cnt;
      pulse_start();
      wait_done(seen, p, f);
      check(seen && p, "R6 restart passes", {seen, p}, 3);
      check(rd_cnt - rd_base == 2, "R6 restart takes two fresh reads", rd_cnt - rd_base, 2);
      tick();

      // start while busy is ignored
      load_script(8'b00000010, 8'h00);
      rd_base = rd_cnt;
      db = done_cnt;
      pulse_start();
      for (int k = 0; k < 40 && rd_cnt - rd_base < 1; k++) tick();
      pulse_start();
      wait_done(seen, p, f);
      tick();
      for (int k = 0; k < 20; k++) tick();
      check(done_cnt - db == 1, "R8 single strobe with start while busy", done_cnt - db, 1);
      check(rd_cnt - rd_base == 4, "R8 start while busy leaves reads unchanged", rd_cnt - rd_base, 4);
      check(!busy_o, "R8 idle afterwards", busy_o, 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
      $finish;
   end

endmodule